// File: doc/BRIEF.md
# Prefixed Shift and Bit-Operation Unit

This execution unit handles the byte that follows the bit-manipulation prefix in an 8-bit processor core. It decodes the sub-opcode, picks the operand from either the register-file read port or a memory-operand input, and computes a result and new flags. It also reports where the result goes: a register index, memory at HL, or nowhere. Prefix detection and the memory cycles themselves belong to the surrounding core.

Requests arrive on a valid/ready input stream. Results leave on a valid/ready output stream through a single output register. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so one result per cycle flows at full rate. When the consumer holds `out_ready` low, the held result stays unchanged and the input stalls. The flag vector is ordered {Z, N, H, C}, with Z in bit 3 and C in bit 0.

Top module: `bitop_unit`

## Requirements
- R1: Sub-opcode bits 7:6 select the class: 00 shift/rotate, 01 bit test, 10 bit reset, 11 bit set. For test, reset and set, bits 5:3 give the bit index.
- R2: Sub-opcode bits 2:0 select the operand: the value 6 takes `in_mem_val` and reports `out_wb_mem`=1. Every other value takes `in_reg_val`. `out_wb_reg` always equals bits 2:0.
- R3: In the shift class, bits 5:3 values 0..3 select the following rotates. RLC rotates left and copies old bit 7 to C. RRC rotates right and copies old bit 0 to C. RL rotates left through C. RR rotates right through C.
- R4: In the shift class, bits 5:3 values 4, 5 and 7 select three shifts. SLA shifts left and fills with 0. SRA shifts right and keeps bit 7. SRL shifts right and fills with 0. In each case the bit that leaves the byte goes to C.
- R5: In the shift class, bits 5:3 value 6 selects SWAP, which exchanges the two nibbles and clears C.
- R6: A shift-class result sets Z when the result is zero, clears N and H, and has `out_wb_en`=1.
- R7: A bit test sets Z to the inverse of the selected bit, clears N, sets H and keeps C. It gives `out_wb_en`=0, and its result equals the operand.
- R8: Bit reset clears, and bit set sets, the selected bit of the operand. Both give `out_wb_en`=1 and pass the input flags through unchanged.
- R9: `in_ready` is high whenever `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all outputs hold their values.
- R10: During and after reset, `out_valid` is 0 until a request is accepted, and every accepted request produces exactly one output, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_sub_op | input | 8 | Sub-opcode after the prefix |
| in_reg_val | input | 8 | Register-file read value |
| in_mem_val | input | 8 | Memory operand at HL |
| in_flags | input | 4 | Current flags {Z,N,H,C} |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 8 | Computed byte |
| out_wb_en | output | 1 | Result must be written back |
| out_wb_mem | output | 1 | Write-back target is memory at HL |
| out_wb_reg | output | 3 | Operand/target index |
| out_flags | output | 4 | New flags {Z,N,H,C} |

## Verification
The assertions check the following on every cycle:
- the handshake rules, and the stability of a stalled result;
- that an empty output register always accepts input;
- the N/H flag pattern for the shift class and for bit tests;
- that flags pass through unchanged for set and reset;
- that the memory target agrees with the operand index.

Only the bench's scenarios can show the arithmetic. Its scoreboard sweeps all 256 sub-opcodes with several operand and flag patterns under random back-pressure. This shows the exact result of each rotate, shift, swap and bit operation, the carry and zero values, the ordering of results, and the selection between register and memory operands.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  localparam int W     = 8;
  localparam int IDX_W = $clog2(W);
  localparam int FL_W  = 4;

  localparam int FZ = 3;
  localparam int FN = 2;
  localparam int FH = 1;
  localparam int FC = 0;

  localparam logic [2:0] MEM_SLOT = 3'd6;

  typedef enum logic [1:0] {
    CL_SHIFT = 2'b00,
    CL_TEST  = 2'b01,
    CL_CLR   = 2'b10,
    CL_SET   = 2'b11
  } op_class_t;

  typedef enum logic [2:0] {
    SH_RLC  = 3'd0,
    SH_RRC  = 3'd1,
    SH_RL   = 3'd2,
    SH_RR   = 3'd3,
    SH_SLA  = 3'd4,
    SH_SRA  = 3'd5,
    SH_SWAP = 3'd6,
    SH_SRL  = 3'd7
  } shift_kind_t;

  typedef struct packed {
    logic [W-1:0]    result;
    logic [FL_W-1:0] flags;
    logic            wb_en;
  } exec_out_t;
endpackage

// File: rtl/bitop_shift.sv
module bitop_shift
  import bitop_pkg::*;
(
  input  shift_kind_t     kind,
  input  logic [W-1:0]    opnd,
  input  logic            cin,
  output logic [W-1:0]    res,
  output logic [FL_W-1:0] flg
);
  localparam int HALF = W / 2;
  logic cout;

  always_comb begin
    res  = opnd;
    cout = 1'b0;
    unique case (kind)
      SH_RLC:  begin res = {opnd[W-2:0], opnd[W-1]}; cout = opnd[W-1]; end
      SH_RRC:  begin res = {opnd[0], opnd[W-1:1]};   cout = opnd[0];   end
      SH_RL:   begin res = {opnd[W-2:0], cin};       cout = opnd[W-1]; end
      SH_RR:   begin res = {cin, opnd[W-1:1]};       cout = opnd[0];   end
      SH_SLA:  begin res = {opnd[W-2:0], 1'b0};      cout = opnd[W-1]; end
      SH_SRA:  begin res = {opnd[W-1], opnd[W-1:1]}; cout = opnd[0];   end
      SH_SWAP: begin res = {opnd[HALF-1:0], opnd[W-1:HALF]}; cout = 1'b0; end
      SH_SRL:  begin res = {1'b0, opnd[W-1:1]};      cout = opnd[0];   end
      default: begin res = opnd; cout = 1'b0; end
    endcase
    flg     = '0;
    flg[FZ] = (res == '0);
    flg[FC] = cout;
  end
endmodule

// File: rtl/bitop_bitfn.sv
module bitop_bitfn
  import bitop_pkg::*;
(
  input  op_class_t        cls,
  input  logic [IDX_W-1:0] bidx,
  input  logic [W-1:0]     opnd,
  input  logic [FL_W-1:0]  fin,
  output logic [W-1:0]     res,
  output logic [FL_W-1:0]  flg,
  output logic             wb
);
  logic [W-1:0] mask;
  assign mask = {{(W-1){1'b0}}, 1'b1} << bidx;

  always_comb begin
    res = opnd;
    flg = fin;
    wb  = 1'b1;
    unique case (cls)
      CL_TEST: begin
        wb      = 1'b0;
        flg[FZ] = ~|(opnd & mask);
        flg[FN] = 1'b0;
        flg[FH] = 1'b1;
      end
      CL_CLR:  res = opnd & ~mask;
      CL_SET:  res = opnd | mask;
      default: res = opnd;
    endcase
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W-1:0]    in_sub_op,
  input  logic [W-1:0]    in_reg_val,
  input  logic [W-1:0]    in_mem_val,
  input  logic [FL_W-1:0] in_flags,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_result,
  output logic            out_wb_en,
  output logic            out_wb_mem,
  output logic [2:0]      out_wb_reg,
  output logic [FL_W-1:0] out_flags
);
  op_class_t   cls;
  shift_kind_t skind;
  logic [2:0]  slot;
  logic [W-1:0] opnd;
  logic [W-1:0] sh_res, bf_res;
  logic [FL_W-1:0] sh_flg, bf_flg;
  logic bf_wb;
  exec_out_t nxt;
  logic accept;

  assign cls   = op_class_t'(in_sub_op[7:6]);
  assign skind = shift_kind_t'(in_sub_op[5:3]);
  assign slot  = in_sub_op[2:0];
  assign opnd  = (slot == MEM_SLOT) ? in_mem_val : in_reg_val;

  bitop_shift u_shift (
    .kind (skind),
    .opnd (opnd),
    .cin  (in_flags[FC]),
    .res  (sh_res),
    .flg  (sh_flg)
  );

  bitop_bitfn u_bitfn (
    .cls  (cls),
    .bidx (in_sub_op[5:3]),
    .opnd (opnd),
    .fin  (in_flags),
    .res  (bf_res),
    .flg  (bf_flg),
    .wb   (bf_wb)
  );

  always_comb begin
    if (cls == CL_SHIFT) begin
      nxt.result = sh_res;
      nxt.flags  = sh_flg;
      nxt.wb_en  = 1'b1;
    end else begin
      nxt.result = bf_res;
      nxt.flags  = bf_flg;
      nxt.wb_en  = bf_wb;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
      out_wb_en  <= 1'b0;
      out_wb_mem <= 1'b0;
      out_wb_reg <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= nxt.result;
      out_flags  <= nxt.flags;
      out_wb_en  <= nxt.wb_en;
      out_wb_mem <= (slot == MEM_SLOT);
      out_wb_reg <= slot;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk
  import bitop_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [W-1:0]    in_sub_op,
  input logic [FL_W-1:0] in_flags,
  input logic            out_valid,
  input logic            out_ready,
  input logic [W-1:0]    out_result,
  input logic            out_wb_en,
  input logic            out_wb_mem,
  input logic [2:0]      out_wb_reg,
  input logic [FL_W-1:0] out_flags
);
  a_r9_empty_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_flags) && $stable(out_wb_en) && $stable(out_wb_reg)));

  a_r10_accept_yields: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r6_shift_nh_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sub_op[7:6] == 2'b00) |=>
      (out_flags[FN] == 1'b0 && out_flags[FH] == 1'b0 && out_wb_en));

  a_r7_test_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sub_op[7:6] == 2'b01) |=>
      (!out_wb_en && !out_flags[FN] && out_flags[FH] &&
       out_flags[FC] == $past(in_flags[FC])));

  a_r8_flags_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_sub_op[7]) |=>
      (out_wb_en && out_flags == $past(in_flags)));

  a_r2_mem_target: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_wb_mem == (out_wb_reg == MEM_SLOT)));
endmodule

bind bitop_unit bitop_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_sub_op  (in_sub_op),
  .in_flags   (in_flags),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_wb_en  (out_wb_en),
  .out_wb_mem (out_wb_mem),
  .out_wb_reg (out_wb_reg),
  .out_flags  (out_flags)
);

// File: tb/sim_bitop_unit.sv
`timescale 1ns/1ps
module sim_bitop_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_sub_op = '0, in_reg_val = '0, in_mem_val = '0;
  logic [3:0] in_flags = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_result;
  logic out_wb_en, out_wb_mem;
  logic [2:0] out_wb_reg;
  logic [3:0] out_flags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [16:0] expq[$];
  string tagq[$];

  always #10 clk = ~clk;

  bitop_unit u0 (.*);

  // Model: {wb_en, wb_mem, wb_reg[2:0], result[7:0], flags[3:0]}, flags {Z,N,H,C}
  function automatic logic [16:0] model(input logic [7:0] op, input logic [7:0] rv,
                                        input logic [7:0] mv, input logic [3:0] f);
    logic [7:0] x, r;
    logic [3:0] nf;
    logic c, we;
    x  = (op[2:0] == 3'd6) ? mv : rv;
    r  = x; nf = f; we = 1'b1; c = 1'b0;
    case (op[7:6])
      2'b00: begin
        case (op[5:3])
          3'd0: begin r = (x << 1) | (x >> 7); c = x[7]; end
          3'd1: begin r = (x >> 1) | (x << 7); c = x[0]; end
          3'd2: begin r = (x << 1) | {7'd0, f[0]}; c = x[7]; end
          3'd3: begin r = (x >> 1) | {f[0], 7'd0}; c = x[0]; end
          3'd4: begin r = x << 1; c = x[7]; end
          3'd5: begin r = (x >> 1) | (x & 8'h80); c = x[0]; end
          3'd6: begin r = (x << 4) | (x >> 4); c = 1'b0; end
          default: begin r = x >> 1; c = x[0]; end
        endcase
        nf = {r == 8'd0, 1'b0, 1'b0, c};
      end
      2'b01: begin we = 1'b0; nf = {~x[op[5:3]], 1'b0, 1'b1, f[0]}; end
      2'b10: r[op[5:3]] = 1'b0;
      default: r[op[5:3]] = 1'b1;
    endcase
    return {we, op[2:0] == 3'd6, op[2:0], r, nf};
  endfunction

  function automatic string req_of(input logic [7:0] op);
    case (op[7:6])
      2'b00: return (op[5:3] == 3'd6) ? "R5" : (op[5] && op[4:3] != 2'b10) ? "R4" : "R3";
      2'b01: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic send(input logic [7:0] op, input logic [7:0] rv,
                      input logic [7:0] mv, input logic [3:0] f);
    @(negedge clk);
    in_valid = 1'b1; in_sub_op = op; in_reg_val = rv; in_mem_val = mv; in_flags = f;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    expq.push_back(model(op, rv, mv, f));
    tagq.push_back(req_of(op));
  endtask

  // back-pressure source
  initial forever begin
    @(negedge clk);
    out_ready = ($urandom_range(0, 3) != 0);
  end

  // monitor / scoreboard
  logic [16:0] got, exp_v, held;
  bit stalled = 1'b0;
  string t;
  initial forever begin
    @(negedge clk); #2;
    if (rst_n && out_valid) begin
      got = {out_wb_en, out_wb_mem, out_wb_reg, out_result, out_flags};
      if (stalled) begin
        checks++;
        if (got !== held) begin
          errors++;
          $display("FAIL R9 stalled output changed act=%h exp=%h", got, held);
        end
      end
      if (out_ready) begin
        stalled = 1'b0;
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected output act=%h exp=none", got);
        end else begin
          exp_v = expq.pop_front();
          t = tagq.pop_front();
          if (got !== exp_v) begin
            errors++;
            $display("FAIL %s (R1 R2 R6) act=%h exp=%h", t, got, exp_v);
          end
        end
      end else begin
        stalled = 1'b1;
        held = got;
        checks++;
        if (in_ready !== 1'b0) begin
          errors++;
          $display("FAIL R9 in_ready while stalled act=%b exp=0", in_ready);
        end
      end
    end
  end

  initial begin
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R10 reset state act=%b%b exp=01", out_valid, in_ready);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int p = 0; p < 4; p++) begin
      for (int op = 0; op < 256; op++) begin
        logic [7:0] rv, mv;
        case (p)
          0: begin rv = 8'h00; mv = 8'hFF; end
          1: begin rv = 8'h80; mv = 8'h01; end
          2: begin rv = 8'h01; mv = 8'h80; end
          default: begin rv = 8'($urandom); mv = 8'($urandom); end
        endcase
        send(8'(op), rv, mv, 4'($urandom));
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog act=%0d pending exp=0", expq.size());
    end
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule